// File: doc/BRIEF.md
# Fractional-Correction Baud Tick Divider

This block turns a fast system clock into a periodic enable pulse, one system-clock cycle wide. It is meant for an infrared pulse modulator/demodulator that needs a time base of about 1.8432 MHz. The divisor is an integer plus a fraction in sixteenths. A down-counter produces each period. A 4-bit phase accumulator adds the fraction every time the counter reloads. When the accumulator carries, the period being loaded gets one extra cycle. Over time the mean tick rate therefore follows the non-integer ratio.

The divisor and fraction arrive as plain input ports and are read only at a reload. The enable input starts and stops the time base. Dropping the enable clears all state, so the next start begins with a full period and an empty accumulator. Control pins are plain levels and the single output is a strobe, so there is no valid/ready handshake and no back-pressure.

Top module: `baud_tick_div`

## Requirements
- R1: `tick` is 0 while `rst_n` is low. `tick` is 0 in every cycle that follows a rising clock edge at which `en` was sampled low.
- R2: After `en` goes high, the first `tick` is high in the cycle after the (`int_div`+1)-th rising edge at which `en` is sampled high. The edge that first sees `en` high counts as the first.
- R3: With `frac_sel` = 0, consecutive ticks are exactly `int_div`+1 cycles apart.
- R4: Each reload adds `frac_sel` to a 4-bit accumulator, modulo 16. A reload whose sum reaches 16 or more loads a period of `int_div`+2 cycles. Any other reload loads a period of `int_div`+1 cycles.
- R5: When `int_div` is nonzero, `tick` is never high in two consecutive cycles.
- R6: `int_div` and `frac_sel` are sampled only on the edge that ends a tick cycle, or on the first enabled edge. A change made inside a period does not alter that period's length.
- R7: Sampling `en` low clears both the counter and the accumulator. A later restart reproduces the same period sequence as a start from reset.
- R8: With `int_div` = 15 and a carry, a period lasts 17 cycles, and the counter never holds a value above 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears counter and accumulator |
| int_div | input | 4 | Integer divisor; nominal period is this value plus one |
| frac_sel | input | 4 | Fraction in sixteenths added per reload |
| tick | output | 1 | One-cycle enable strobe |

## Verification
The hardest case to reach from the ports is a field change inside a period that the accumulator then carries past. Only the lengths of later periods can show that the new fields were taken at the reload and not earlier. The bench waits until the scoreboard has consumed a chosen tick. It then changes both fields two falling edges later, which is safely after the reload edge. The expected queue holds the old fields for the period in progress and the new ones afterwards, with the accumulator kept running across the change. A separate run stops the enable partway through a period and then restarts with a nonzero fraction, which exposes any accumulator state left over from before.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // counter must hold the largest integer divisor plus the carry stretch
  function automatic int cnt_width(input int iw);
    return iw + 1;
  endfunction
endpackage

// File: rtl/baud_frac_accum.sv
module baud_frac_accum #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          reload,
  input  logic [FW-1:0] frac,
  output logic          carry
);
  logic [FW-1:0] phase_q;
  logic [FW:0]   sum;

  assign sum   = {1'b0, phase_q} + {1'b0, frac};
  assign carry = sum[FW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (!en)    phase_q <= '0;
    else if (reload) phase_q <= sum[FW-1:0];
  end
endmodule

// File: rtl/baud_down_counter.sv
module baud_down_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] load_val,
  output logic          reload,
  output logic          tick,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign tick   = run_q && (cnt_q == '0);
  assign reload = en && (!run_q || (cnt_q == '0));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (reload) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/baud_tick_div.sv
module baud_tick_div #(
  parameter int IW = 4,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [IW-1:0] int_div,
  input  logic [FW-1:0] frac_sel,
  output logic          tick
);
  import baud_pkg::*;
  localparam int CW = cnt_width(IW);

  logic          carry;
  logic          reload;
  logic [CW-1:0] load_val;
  logic [CW-1:0] cnt_w;

  assign load_val = {1'b0, int_div} + {{(CW-1){1'b0}}, carry};

  baud_frac_accum #(.FW(FW)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .reload (reload),
    .frac   (frac_sel),
    .carry  (carry)
  );

  baud_down_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .load_val (load_val),
    .reload   (reload),
    .tick     (tick),
    .cnt_o    (cnt_w)
  );
endmodule

// File: rtl/baud_tick_div_chk.sv
module baud_tick_div_chk #(
  parameter int IW = 4,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [IW-1:0] int_div,
  input logic          tick,
  input logic [CW-1:0] cnt
);
  localparam int CMAX = (1 << IW);

  logic en_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (tick == 1'b0);
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick);

  assert_first_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !en_q && int_div != '0) |=> !tick);

  assert_no_double_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && int_div != '0) |=> !tick);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (int'(cnt) <= CMAX));
endmodule

bind baud_tick_div baud_tick_div_chk #(.IW(IW), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .int_div (int_div),
  .tick    (tick),
  .cnt     (cnt_w)
);

// File: tb/baud_tick_div_tb.sv
module baud_tick_div_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] int_div = '0;
  logic [3:0] frac_sel = '0;
  logic       tick;

  int n_tests = 0;
  int n_fail  = 0;
  int run_n   = 0;
  int exp_q[$];
  string tag = "R1";

  always #5 clk = ~clk;

  baud_tick_div u_dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .int_div(int_div), .frac_sel(frac_sel), .tick(tick)
  );

  // monitor: sampled 2 ns after each rising edge
  always begin
    @(posedge clk);
    #2;
    if (!rst_n) begin
      n_tests++;
      if (tick !== 1'b0) begin
        n_fail++;
        $display("FAIL R1 reset: tick=%0b expected 0", tick);
      end
    end else if (!en) begin
      run_n = 0;
      n_tests++;
      if (tick !== 1'b0) begin
        n_fail++;
        $display("FAIL R1 idle: tick=%0b expected 0", tick);
      end
    end else begin
      run_n++;
      if (exp_q.size() > 0 && run_n == exp_q[0]) begin
        n_tests++;
        if (tick !== 1'b1) begin
          n_fail++;
          $display("FAIL %s: tick=%0b at cycle %0d expected 1", tag, tick, run_n);
        end
        void'(exp_q.pop_front());
      end else if (tick === 1'b1) begin
        n_tests++;
        n_fail++;
        $display("FAIL %s: tick=1 at cycle %0d expected 0 (next due %0d)", tag, run_n,
                 exp_q.size() > 0 ? exp_q[0] : -1);
      end
    end
  end

  // driver: predicts tick positions, then applies stimulus
  task automatic run_case(input int d, input int f, input int n,
                          input int d2, input int f2, input int sw);
    int acc = 0;
    int cum = 0;
    for (int i = 1; i <= n; i++) begin
      int dd = (sw != 0 && i > sw + 1) ? d2 : d;
      int ff = (sw != 0 && i > sw + 1) ? f2 : f;
      int s  = acc + ff;
      cum += dd + 1 + ((s >= 16) ? 1 : 0);
      acc = s % 16;
      exp_q.push_back(cum);
    end
    @(negedge clk);
    int_div  = 4'(d);
    frac_sel = 4'(f);
    en       = 1'b1;
    if (sw != 0) begin
      wait (exp_q.size() == n - sw);
      @(negedge clk);
      @(negedge clk);
      int_div  = 4'(d2);
      frac_sel = 4'(f2);
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    tag = "R2_R3"; run_case(5, 0, 5, 0, 0, 0);      // plain period 6
    tag = "R3";    run_case(1, 0, 6, 0, 0, 0);      // plain period 2
    tag = "R4";    run_case(3, 4, 8, 0, 0, 0);      // 4,4,4,5 pattern
    tag = "R4";    run_case(2, 13, 10, 0, 0, 0);
    tag = "R5";    run_case(0, 8, 8, 0, 0, 0);      // alternating 1 and 2
    tag = "R8";    run_case(15, 15, 6, 0, 0, 0);    // 16 then 17s
    tag = "R6";    run_case(3, 0, 6, 6, 5, 2);      // change mid period 3
    tag = "R6";    run_case(5, 9, 7, 2, 3, 3);
    // R7: stop partway, nothing may tick, restart must start fresh
    tag = "R7";
    @(negedge clk);
    int_div = 4'd7; frac_sel = 4'd11; en = 1'b1;
    repeat (5) @(negedge clk);
    en = 1'b0;
    repeat (4) @(negedge clk);
    tag = "R7"; run_case(7, 11, 5, 0, 0, 0);
    tag = "R7"; run_case(7, 11, 5, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule